// File: doc/BRIEF.md
# Receive Character Buffer with Error Tracking

This block is the receive-side character queue of a serial port. The receiver pushes each completed character together with three error indications: a break marker, a framing fault and a parity fault. Software reads characters from the head of the queue. Each read pops one entry.

At all times the block shows the data and the three error flags of the head character. It also keeps a running count of stored entries that carry any error. From that count it drives a summary error flag. That flag serves as the request for the line-status interrupt. It stays high until the last erroneous character has left the queue, however many clean characters stand around it.

A push into a full queue is dropped and shown on an overflow output. A synchronous clear input empties the queue. The default depth is 64 entries of 8 data bits.

Top module: `rx_err_fifo`

## Requirements
- R1: An active-low asynchronous reset, or a synchronous `clr` pulse, leaves the queue empty. After either one, `count` is 0, `empty` is 1 and `any_err` is 0. `clr` takes priority over a push or a pop in the same cycle.
- R2: Characters leave in the order they were pushed. `rd_data`, `head_brk`, `head_frm` and `head_par` show the data and flags of the oldest stored entry, with no read latency.
- R3: A pop (`rd_en` while not empty) removes the head at the clock edge. In the next cycle the head outputs show the following entry.
- R4: While the queue is empty, `rd_data` and all three head flags read 0.
- R5: `any_err` is 1 exactly when at least one stored entry has at least one of its three flags set.
- R6: `any_err` falls only at a pop of the last stored erroneous entry, or at a clear.
- R7: `overflow` is combinationally `wr_en & full & ~rd_en`. Such a push is dropped, and the count and contents stay unchanged.
- R8: `rd_en` while empty has no effect.
- R9: A push and a pop in the same cycle are both taken, including when the queue is full. The count is then unchanged, and the error tally is adjusted for both entries.
- R10: `count` gives the number of stored entries, from 0 to DEPTH. `empty` is `count==0` and `full` is `count==DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous queue clear |
| wr_en | input | 1 | Push request from the receiver |
| wr_data | input | DW | Character to push |
| wr_brk | input | 1 | Break marker of the pushed character |
| wr_frm | input | 1 | Framing fault of the pushed character |
| wr_par | input | 1 | Parity fault of the pushed character |
| rd_en | input | 1 | Pop request (data-register read) |
| rd_data | output | DW | Head character |
| head_brk | output | 1 | Break marker of the head |
| head_frm | output | 1 | Framing fault of the head |
| head_par | output | 1 | Parity fault of the head |
| any_err | output | 1 | Some stored entry carries an error |
| empty | output | 1 | No entries stored |
| full | output | 1 | DEPTH entries stored |
| count | output | $clog2(DEPTH+1) | Number of stored entries |
| overflow | output | 1 | Push dropped because the queue is full |

## Verification
The bench uses an 8-deep instance. It covers several cases:
- A simultaneous push and pop on a full queue. A design that refused this push would lose a character and lower the count.
- A pop of an erroneous head while an erroneous character is pushed. A design that updated its error tally for only one side would drift and leave `any_err` stuck or clear it early.
- Pops on an empty queue. A design that did not ignore them would wrap the count.
- A head that has just become empty. A design that did not mask the flags would expose stale flags.
- Clears mixed into random traffic, to show that the tally is reset together with the entries.

// File: rtl/rx_err_fifo.sv
module rx_err_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       wr_en,
  input  logic [DW-1:0]              wr_data,
  input  logic                       wr_brk,
  input  logic                       wr_frm,
  input  logic                       wr_par,
  input  logic                       rd_en,
  output logic [DW-1:0]              rd_data,
  output logic                       head_brk,
  output logic                       head_frm,
  output logic                       head_par,
  output logic                       any_err,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DW + 3;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, ecnt;

  wire [EW-1:0] head    = mem[rp];
  wire          do_pop  = rd_en & ~empty;
  wire          do_push = wr_en & (~full | do_pop);
  wire          in_err  = wr_brk | wr_frm | wr_par;
  wire          out_err = |head[2:0];

  assign empty    = (cnt == '0);
  assign full     = (cnt == FULLV);
  assign count    = cnt;
  assign any_err  = (ecnt != '0);
  assign overflow = wr_en & full & ~rd_en;
  assign rd_data  = empty ? '0 : head[EW-1:3];
  assign head_brk = ~empty & head[2];
  assign head_frm = ~empty & head[1];
  assign head_par = ~empty & head[0];

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= {wr_data, wr_brk, wr_frm, wr_par};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      ecnt <= '0;
    end else if (clr) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      ecnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + AW'(1);
      cnt  <= cnt + CW'(do_push) - CW'(do_pop);
      ecnt <= ecnt + CW'(do_push & in_err) - CW'(do_pop & out_err);
    end
  end
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       clr,
  input logic                       wr_en,
  input logic                       wr_brk,
  input logic                       wr_frm,
  input logic                       wr_par,
  input logic                       rd_en,
  input logic                       head_brk,
  input logic                       head_frm,
  input logic                       head_par,
  input logic                       any_err,
  input logic                       empty,
  input logic                       full,
  input logic [$clog2(DEPTH+1)-1:0] count,
  input logic                       overflow
);
  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && !any_err && count == '0));

  assert_empty_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !(head_brk || head_frm || head_par));

  assert_err_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (!full || rd_en) && (wr_brk || wr_frm || wr_par) && !clr) |=> any_err);

  assert_err_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_err) |-> ($past(clr) || $past(rd_en && !empty)));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr) |=> (count == $past(count)));

  assert_pop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !wr_en && !clr) |=> empty);

  assert_both_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && full && !clr) |=> full);

  assert_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (empty == (count == '0)) && !(empty && full));
endmodule

bind rx_err_fifo rx_err_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_brk(wr_brk),
  .wr_frm(wr_frm), .wr_par(wr_par), .rd_en(rd_en), .head_brk(head_brk),
  .head_frm(head_frm), .head_par(head_par), .any_err(any_err),
  .empty(empty), .full(full), .count(count), .overflow(overflow)
);

// File: tb/rx_err_fifo_bench.sv
`timescale 1ns/1ps
module rx_err_fifo_bench;
  localparam int D  = 8;
  localparam int DW = 8;
  localparam int CW = $clog2(D + 1);

  logic clk = 0, rst_n = 0, clr = 0, wr_en = 0, rd_en = 0;
  logic wr_brk = 0, wr_frm = 0, wr_par = 0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic head_brk, head_frm, head_par, any_err, empty, full, overflow;
  logic [CW-1:0] count;

  always #2 clk = ~clk;

  rx_err_fifo #(.DEPTH(D), .DW(DW)) u_rx_err_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
    .wr_brk(wr_brk), .wr_frm(wr_frm), .wr_par(wr_par), .rd_en(rd_en),
    .rd_data(rd_data), .head_brk(head_brk), .head_frm(head_frm),
    .head_par(head_par), .any_err(any_err), .empty(empty), .full(full),
    .count(count), .overflow(overflow)
  );

  int total = 0, bad = 0;
  logic [10:0] q[$];
  logic [31:0] seed = 32'h1234_5678;
  logic prev_err = 0, last_pop = 0, last_both = 0, last_npop = 0, last_clr = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  task automatic check_outs();
    int n = q.size();
    int nerr = 0;
    logic [10:0] h = (n > 0) ? q[0] : 11'd0;
    string hr = (n == 0) ? "R4" : (last_pop ? "R3" : "R2");
    string cr = last_clr ? "R1" : (last_both ? "R9" : (last_npop ? "R8" : "R10"));
    string er;
    foreach (q[i]) if (q[i][2:0] != 0) nerr++;
    er = last_clr ? "R1" : ((prev_err && nerr == 0) ? "R6" : "R5");
    chk(count == CW'(n), cr, count, n);
    chk(empty == (n == 0), "R10", empty, n == 0);
    chk(full == (n == D), "R10", full, n == D);
    chk(rd_data == h[10:3], hr, rd_data, h[10:3]);
    chk({head_brk, head_frm, head_par} == h[2:0], hr,
        {head_brk, head_frm, head_par}, h[2:0]);
    chk(any_err == (nerr != 0), er, any_err, nerr != 0);
    chk(overflow == (wr_en && n == D && !rd_en), "R7", overflow,
        wr_en && n == D && !rd_en);
    prev_err = (nerr != 0);
  endtask

  task automatic step(input bit w, input logic [10:0] e, input bit r, input bit c);
    int n;
    bit pop, push;
    @(negedge clk);
    wr_en = w; {wr_data, wr_brk, wr_frm, wr_par} = e; rd_en = r; clr = c;
    #1 check_outs();
    n = q.size();
    pop = r && n > 0;
    push = w && (n < D || pop);
    @(posedge clk);
    last_clr = c; last_pop = pop && !c; last_both = pop && push && !c;
    last_npop = r && n == 0 && !c;
    if (c) q.delete();
    else begin
      if (pop) void'(q.pop_front());
      if (push) q.push_back(e);
    end
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1 check_outs();
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R8: pops on empty queue
    step(0, 0, 1, 0); step(0, 0, 1, 0);
    // R2, R7: fill past full with every flag combination, then overflow
    for (int i = 0; i < D + 3; i++) step(1, {8'(8'hA0 + i), 3'(i)}, 0, 0);
    // R9: push and pop together while full, with errors in and out
    for (int i = 0; i < 4; i++) step(1, {8'(8'h50 + i), 3'(i + 3)}, 1, 0);
    // R3, R6: drain, including pops past empty
    for (int i = 0; i < D + 2; i++) step(0, 0, 1, 0);
    // R6: one erroneous entry surrounded by clean ones
    step(1, {8'h11, 3'b000}, 0, 0); step(1, {8'h22, 3'b010}, 0, 0);
    step(1, {8'h33, 3'b000}, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0);
    // R1: clear a partly filled queue holding errors
    step(1, {8'h44, 3'b100}, 0, 0); step(1, {8'h55, 3'b001}, 0, 0);
    step(1, {8'h66, 3'b000}, 1, 1); step(0, 0, 0, 0);
    // mixed random traffic with rare clears
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] v = rnd();
      logic [31:0] f = rnd();
      step(v[0] | v[1], {v[15:8], (f[3:0] == 0) ? f[6:4] : 3'b000},
           v[2] & (v[3] | v[4]), v[23:16] == 8'h00);
    end
    for (int i = 0; i < D + 1; i++) step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule